// File: doc/BRIEF.md
# Virtual Interrupt Acknowledge and Completion Engine

This block holds the per-processor virtual interrupt state seen through the register-access path: a small file of list entries, each with an ID, a priority, a group, a non-maskable flag and pending/active state bits, and one active-priority bit vector per group. It carries out the processor's acknowledge reads, its non-maskable acknowledge reads and its completion writes. Each one updates the list entries and the active-priority bits. An external selector supplies the highest-priority candidate entry and a preemption verdict. This block acts on that choice and does not make it.

A non-maskable interrupt does not use a priority bit. It takes one dedicated flag that sits at bit 63 of group-1 active-priority register 0. A plain acknowledge refuses a non-maskable candidate with ID 1022 and leaves it pending, so the guest has to use the dedicated acknowledge. Completion first drops the non-maskable flag if it is set. Otherwise it drops the highest active priority. It then retires the list entry that matches. The same command port also gives access to the list entries, the active-priority registers and the running priority, which is how software, and the bench, observe the state.

Top module: `vint_ack_eoi`

## Requirements
- R1: Opcodes on cmd_op_i are 0 acknowledge, 1 non-maskable acknowledge, 2 completion, 3 priority-register write, 4 priority-register read, 5 running-priority read, 6 list write and 7 list read. A command with cmd_valid_i high gives exactly one done_o pulse in the next cycle, with rdata_o valid at the same time. done_o stays low when no command was given. After reset, done_o and rdata_o are 0.
- R2: A list word is {active[35], pending[34], nmi[33], group1[32], priority[31:24], id[23:0]}. A list write stores bits [35:0] of cmd_wdata_i in entry cmd_idx_i. A list read returns that entry zero-extended to 64 bits.
- R3: An acknowledge (group cmd_grp_i) of a selected entry that is pending and not active, in the same group, with sel_preempt_i high, non-special and not flagged non-maskable, returns the entry's ID, clears pending and sets active. It also sets active-priority bit k = (priority masked to its top pre_bits_i bits) >> (8 - pre_bits_i), in register k/32 at bit k%32 of the entry's group.
- R4: An acknowledge whose candidate is invalid, not pending, in the other group or not allowed to preempt returns 1023 and changes nothing.
- R5: With nmi_en_i high, an acknowledge of a non-maskable candidate returns 1022 and leaves the entry and the priority bits unchanged. With nmi_en_i low, the flag is ignored and the entry is acknowledged as in R3.
- R6: A non-maskable acknowledge accepts only a pending group-1 entry with the flag set while nmi_en_i is high. It activates the entry and sets only bit 63 of group-1 register 0. In every other case it returns 1023 and changes nothing.
- R7: When an acknowledge of either kind accepts an entry whose ID is 1020 to 1023, that ID is returned and pending is cleared. The entry is not made active and no priority bit changes.
- R8: On completion, if the non-maskable flag is set and nmi_en_i is high, only that flag is cleared. Then the active flagged entry with the written ID (bits [23:0]) in group cmd_grp_i is deactivated.
- R9: Otherwise completion clears the lowest-numbered set active-priority bit across both groups, taking group 0 when both groups hold that bit. It then deactivates the active unflagged entry of group cmd_grp_i that has the written ID and whose masked priority equals the dropped bit index << (8 - pre_bits_i).
- R10: Completion with no active-priority bit and no non-maskable flag set changes no list entry.
- R11: With split_eoi_i high, a completion whose ID is below 8192 drops the priority but leaves the entry active. IDs of 8192 and above are still deactivated.
- R12: A priority-register write (cmd_grp_i, register cmd_idx_i) stores bits [31:0]. Bit 63 is kept only for group-1 register 0 while nmi_en_i is high, and is stored as 0 otherwise. A read returns the stored bits with that flag at bit 63.
- R13: A running-priority read returns 0x80 with bit 63 set when the non-maskable flag is set and nmi_en_i is high. Otherwise it returns (lowest set bit index across both groups) << (8 - pre_bits_i), or 0xFF when no bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Opcode |
| cmd_grp_i | input | 1 | Group: 0 or 1 |
| cmd_idx_i | input | IDX_W | List entry or priority register index |
| cmd_wdata_i | input | 64 | Write data or completion ID |
| sel_valid_i | input | 1 | Selector has a candidate |
| sel_idx_i | input | LR_IDX_W | Candidate list entry |
| sel_preempt_i | input | 1 | Candidate may preempt |
| pre_bits_i | input | 3 | Preemption bit count, 5 to MAX_PRE |
| nmi_en_i | input | 1 | Non-maskable support strap |
| split_eoi_i | input | 1 | Split priority drop and deactivation |
| rdata_o | output | 64 | Read result |
| done_o | output | 1 | Completion pulse |

## Verification
The assertions check on every cycle that each command produces exactly one done pulse, and that a refused plain acknowledge, a rejected non-maskable acknowledge and a completion with nothing active leave the list entries untouched. They also check that the non-maskable flag only rises while support is strapped on, and that setting it never disturbs the group priority bits. Only the bench scenarios can show that the returned IDs and the computed bit positions are correct under different preemption widths. The same holds for the group-0 preference when both groups share a bit index, the ordering of the non-maskable drop before the priority drop, and the split-mode deactivation boundary.

// File: rtl/vint_pkg.sv
package vint_pkg;
  localparam int ID_W   = 24;
  localparam int PRIO_W = 8;
  localparam int LR_W   = 36;

  localparam logic [ID_W-1:0] ID_NMI_REFUSED = 24'd1022;
  localparam logic [ID_W-1:0] ID_SPURIOUS    = 24'd1023;
  localparam logic [ID_W-1:0] ID_LPI_BASE    = 24'd8192;

  typedef enum logic [2:0] {
    OP_ACK     = 3'd0,
    OP_NMI_ACK = 3'd1,
    OP_EOI     = 3'd2,
    OP_APR_WR  = 3'd3,
    OP_APR_RD  = 3'd4,
    OP_RPR_RD  = 3'd5,
    OP_LR_WR   = 3'd6,
    OP_LR_RD   = 3'd7
  } vint_op_e;

  typedef struct packed {
    logic              active;
    logic              pending;
    logic              nmi;
    logic              grp1;
    logic [PRIO_W-1:0] prio;
    logic [ID_W-1:0]   id;
  } vint_lr_t;

  function automatic logic is_special(input logic [ID_W-1:0] id);
    return (id >= 24'd1020) && (id <= 24'd1023);
  endfunction
endpackage

// File: rtl/vint_lr_file.sv
module vint_lr_file
  import vint_pkg::*;
#(
  parameter int NUM_LR   = 4,
  parameter int LR_IDX_W = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                upd_en_i,
  input  logic [LR_IDX_W-1:0] upd_idx_i,
  input  vint_lr_t            upd_data_i,
  output vint_lr_t            lr_o [NUM_LR]
);
  for (genvar g = 0; g < NUM_LR; g++) begin : g_entry
    vint_lr_t entry_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) entry_q <= '0;
      else if (upd_en_i && (int'(upd_idx_i) == g)) entry_q <= upd_data_i;
    end
    assign lr_o[g] = entry_q;
  end
endmodule

// File: rtl/vint_apr_regs.sv
module vint_apr_regs #(
  parameter int NUM_APR = 4,
  parameter int AIDX_W  = 2,
  parameter int BIT_W   = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  wr_grp_i,
  input  logic [AIDX_W-1:0]     wr_idx_i,
  input  logic [31:0]           wr_data_i,
  input  logic                  wr_nmi_i,
  input  logic                  set_en_i,
  input  logic                  set_grp_i,
  input  logic [BIT_W-1:0]      set_bit_i,
  input  logic                  clr_en_i,
  input  logic                  clr_grp_i,
  input  logic [BIT_W-1:0]      clr_bit_i,
  input  logic                  nmi_set_i,
  input  logic                  nmi_clr_i,
  output logic [NUM_APR*32-1:0] g0_o,
  output logic [NUM_APR*32-1:0] g1_o,
  output logic                  nmi_o
);
  localparam int NBITS = NUM_APR * 32;

  logic [NBITS-1:0] g_q [2];
  logic [NBITS-1:0] g_n [2];
  logic             nmi_q, nmi_n;
  logic             wr_in_range;

  assign wr_in_range = int'(wr_idx_i) < NUM_APR;

  always_comb begin
    g_n[0] = g_q[0];
    g_n[1] = g_q[1];
    nmi_n  = nmi_q;
    if (wr_en_i && wr_in_range) begin
      g_n[wr_grp_i][int'(wr_idx_i)*32 +: 32] = wr_data_i;
      if (wr_grp_i && (wr_idx_i == '0)) nmi_n = wr_nmi_i;
    end
    if (set_en_i) g_n[set_grp_i][set_bit_i] = 1'b1;
    if (clr_en_i) g_n[clr_grp_i][clr_bit_i] = 1'b0;
    if (nmi_set_i) nmi_n = 1'b1;
    if (nmi_clr_i) nmi_n = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g_q[0] <= '0;
      g_q[1] <= '0;
      nmi_q  <= 1'b0;
    end else begin
      g_q[0] <= g_n[0];
      g_q[1] <= g_n[1];
      nmi_q  <= nmi_n;
    end
  end

  assign g0_o  = g_q[0];
  assign g1_o  = g_q[1];
  assign nmi_o = nmi_q;

  AST_NMI_NO_GRP_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_set_i |=> ($stable(g_q[0]) && $stable(g_q[1]))); // R6
endmodule

// File: rtl/vint_prio_scan.sv
module vint_prio_scan #(
  parameter int NBITS = 128,
  parameter int BIT_W = 7
) (
  input  logic [NBITS-1:0] g0_i,
  input  logic [NBITS-1:0] g1_i,
  output logic             found_o,
  output logic [BIT_W-1:0] idx_o,
  output logic             in_g0_o
);
  // lowest index wins; group 0 preferred at equal index
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    in_g0_o = 1'b0;
    for (int i = NBITS - 1; i >= 0; i--) begin
      if (g0_i[i] || g1_i[i]) begin
        found_o = 1'b1;
        idx_o   = BIT_W'(i);
        in_g0_o = g0_i[i];
      end
    end
  end
endmodule

// File: rtl/vint_ack_eoi.sv
module vint_ack_eoi
  import vint_pkg::*;
#(
  parameter int NUM_LR   = 4,
  parameter int MAX_PRE  = 7,
  localparam int NUM_APR  = (1 << MAX_PRE) / 32,
  localparam int APR_BITS = NUM_APR * 32,
  localparam int BIT_W    = $clog2(APR_BITS),
  localparam int AIDX_W   = (NUM_APR > 1) ? $clog2(NUM_APR) : 1,
  localparam int LR_IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1,
  localparam int IDX_W    = (AIDX_W > LR_IDX_W) ? AIDX_W : LR_IDX_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [2:0]          cmd_op_i,
  input  logic                cmd_grp_i,
  input  logic [IDX_W-1:0]    cmd_idx_i,
  input  logic [63:0]         cmd_wdata_i,
  input  logic                sel_valid_i,
  input  logic [LR_IDX_W-1:0] sel_idx_i,
  input  logic                sel_preempt_i,
  input  logic [2:0]          pre_bits_i,
  input  logic                nmi_en_i,
  input  logic                split_eoi_i,
  output logic [63:0]         rdata_o,
  output logic                done_o
);
  vint_lr_t lr_q [NUM_LR];
  logic [NUM_LR*LR_W-1:0] lr_flat;

  logic                lr_upd_en;
  logic [LR_IDX_W-1:0] lr_upd_idx;
  vint_lr_t            lr_upd_data;

  logic                apr_wr_en, apr_wr_nmi;
  logic                apr_set_en, apr_set_grp;
  logic [BIT_W-1:0]    apr_set_bit;
  logic                apr_clr_en, apr_clr_grp;
  logic [BIT_W-1:0]    apr_clr_bit;
  logic                apr_nmi_set, apr_nmi_clr;
  logic [APR_BITS-1:0] apr_g0, apr_g1;
  logic                apr_nmi;

  logic                scan_found, scan_in_g0;
  logic [BIT_W-1:0]    scan_idx;

  vint_op_e            op;
  logic [3:0]          shift;
  logic [7:0]          gmask, act_full, scan_prio;
  logic [BIT_W-1:0]    act_bit;
  vint_lr_t            sel_lr;
  logic                sel_ok, drop_nmi, eoi_hit;
  logic [LR_IDX_W-1:0] eoi_idx;
  logic [LR_IDX_W-1:0] cmd_lr_idx;
  logic [AIDX_W-1:0]   cmd_apr_idx;
  logic [31:0]         apr_rd_word;
  logic [63:0]         rdata_n;
  logic [26:0]         wdata_unused;

  vint_lr_file #(.NUM_LR(NUM_LR), .LR_IDX_W(LR_IDX_W)) u_lr (
    .clk_i, .rst_ni,
    .upd_en_i   (lr_upd_en),
    .upd_idx_i  (lr_upd_idx),
    .upd_data_i (lr_upd_data),
    .lr_o       (lr_q)
  );

  vint_apr_regs #(.NUM_APR(NUM_APR), .AIDX_W(AIDX_W), .BIT_W(BIT_W)) u_apr (
    .clk_i, .rst_ni,
    .wr_en_i   (apr_wr_en),
    .wr_grp_i  (cmd_grp_i),
    .wr_idx_i  (cmd_apr_idx),
    .wr_data_i (cmd_wdata_i[31:0]),
    .wr_nmi_i  (apr_wr_nmi),
    .set_en_i  (apr_set_en),
    .set_grp_i (apr_set_grp),
    .set_bit_i (apr_set_bit),
    .clr_en_i  (apr_clr_en),
    .clr_grp_i (apr_clr_grp),
    .clr_bit_i (apr_clr_bit),
    .nmi_set_i (apr_nmi_set),
    .nmi_clr_i (apr_nmi_clr),
    .g0_o      (apr_g0),
    .g1_o      (apr_g1),
    .nmi_o     (apr_nmi)
  );

  vint_prio_scan #(.NBITS(APR_BITS), .BIT_W(BIT_W)) u_scan (
    .g0_i    (apr_g0),
    .g1_i    (apr_g1),
    .found_o (scan_found),
    .idx_o   (scan_idx),
    .in_g0_o (scan_in_g0)
  );

  for (genvar g = 0; g < NUM_LR; g++) begin : g_flat
    assign lr_flat[g*LR_W +: LR_W] = lr_q[g];
  end

  assign wdata_unused = cmd_wdata_i[62:36];
  assign op           = vint_op_e'(cmd_op_i);
  assign shift        = 4'd8 - {1'b0, pre_bits_i};
  assign gmask        = 8'hFF << shift;
  assign cmd_lr_idx   = LR_IDX_W'(cmd_idx_i);
  assign cmd_apr_idx  = AIDX_W'(cmd_idx_i);
  assign sel_ok       = sel_valid_i && (int'(sel_idx_i) < NUM_LR);
  assign sel_lr       = lr_q[sel_idx_i];
  assign act_full     = (sel_lr.prio & gmask) >> shift;
  assign act_bit      = BIT_W'(act_full);
  assign scan_prio    = 8'(scan_idx) << shift;
  assign drop_nmi     = nmi_en_i && apr_nmi;
  assign apr_rd_word  = cmd_grp_i ? apr_g1[int'(cmd_apr_idx)*32 +: 32]
                                  : apr_g0[int'(cmd_apr_idx)*32 +: 32];

  // completion target lookup
  always_comb begin
    eoi_hit = 1'b0;
    eoi_idx = '0;
    for (int i = NUM_LR - 1; i >= 0; i--) begin
      if (lr_q[i].active && (lr_q[i].grp1 == cmd_grp_i) &&
          (lr_q[i].id == cmd_wdata_i[ID_W-1:0]) &&
          (drop_nmi ? lr_q[i].nmi
                    : (!(nmi_en_i && lr_q[i].nmi) &&
                       ((lr_q[i].prio & gmask) == scan_prio)))) begin
        eoi_hit = 1'b1;
        eoi_idx = LR_IDX_W'(i);
      end
    end
  end

  always_comb begin
    rdata_n     = '0;
    lr_upd_en   = 1'b0;
    lr_upd_idx  = sel_idx_i;
    lr_upd_data = sel_lr;
    apr_wr_en   = 1'b0;
    apr_wr_nmi  = 1'b0;
    apr_set_en  = 1'b0;
    apr_set_grp = sel_lr.grp1;
    apr_set_bit = act_bit;
    apr_clr_en  = 1'b0;
    apr_clr_grp = !scan_in_g0;
    apr_clr_bit = scan_idx;
    apr_nmi_set = 1'b0;
    apr_nmi_clr = 1'b0;
    if (cmd_valid_i) begin
      case (op)
        OP_ACK, OP_NMI_ACK: begin
          rdata_n = {40'd0, ID_SPURIOUS};
          if (sel_ok && sel_lr.pending && !sel_lr.active &&
              ((op == OP_ACK) ? ((sel_lr.grp1 == cmd_grp_i) && sel_preempt_i)
                              : (nmi_en_i && sel_lr.grp1 && sel_lr.nmi))) begin
            if (is_special(sel_lr.id)) begin
              rdata_n             = {40'd0, sel_lr.id};
              lr_upd_en           = 1'b1;
              lr_upd_data.pending = 1'b0;
            end else if ((op == OP_ACK) && nmi_en_i && sel_lr.nmi) begin
              rdata_n = {40'd0, ID_NMI_REFUSED};
            end else begin
              rdata_n             = {40'd0, sel_lr.id};
              lr_upd_en           = 1'b1;
              lr_upd_data.pending = 1'b0;
              lr_upd_data.active  = 1'b1;
              if (nmi_en_i && sel_lr.nmi) apr_nmi_set = 1'b1;
              else                        apr_set_en  = 1'b1;
            end
          end
        end
        OP_EOI: begin
          if (drop_nmi) apr_nmi_clr = 1'b1;
          else          apr_clr_en  = scan_found;
          if ((drop_nmi || scan_found) && eoi_hit &&
              !(split_eoi_i && (cmd_wdata_i[ID_W-1:0] < ID_LPI_BASE))) begin
            lr_upd_en          = 1'b1;
            lr_upd_idx         = eoi_idx;
            lr_upd_data        = lr_q[eoi_idx];
            lr_upd_data.active = 1'b0;
          end
        end
        OP_APR_WR: begin
          apr_wr_en  = 1'b1;
          apr_wr_nmi = nmi_en_i && cmd_wdata_i[63];
        end
        OP_APR_RD: begin
          rdata_n = {apr_nmi && cmd_grp_i && (cmd_apr_idx == '0), 31'd0, apr_rd_word};
        end
        OP_RPR_RD: begin
          if (drop_nmi)        rdata_n = {1'b1, 55'd0, 8'h80};
          else if (scan_found) rdata_n = {56'd0, scan_prio};
          else                 rdata_n = 64'hFF;
        end
        OP_LR_WR: begin
          lr_upd_en   = int'(cmd_lr_idx) < NUM_LR;
          lr_upd_idx  = cmd_lr_idx;
          lr_upd_data = vint_lr_t'(cmd_wdata_i[LR_W-1:0]);
        end
        OP_LR_RD: begin
          rdata_n = {{(64-LR_W){1'b0}}, lr_q[cmd_lr_idx]};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= cmd_valid_i;
      if (cmd_valid_i) rdata_o <= rdata_n;
    end
  end

  AST_DONE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> done_o); // R1
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !done_o); // R1
  AST_REFUSE_KEEPS_LR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (op == OP_ACK) && sel_ok && sel_lr.pending && !sel_lr.active &&
     sel_lr.nmi && nmi_en_i && !is_special(sel_lr.id)) |=> $stable(lr_flat)); // R5
  AST_NMI_ACK_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (op == OP_NMI_ACK) &&
     !(nmi_en_i && sel_ok && sel_lr.pending && sel_lr.grp1 && sel_lr.nmi))
    |=> ($stable(lr_flat) && $stable(apr_g0) && $stable(apr_g1) && $stable(apr_nmi))); // R6
  AST_EOI_IDLE_NO_LR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (op == OP_EOI) && !drop_nmi && !scan_found) |=> $stable(lr_flat)); // R10
  AST_NMI_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(apr_nmi) |-> $past(nmi_en_i)); // R12
endmodule

// File: tb/vint_ack_eoi_tb.sv
module vint_ack_eoi_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] C_ACK = 3'd0, C_NACK = 3'd1, C_EOI = 3'd2, C_AWR = 3'd3,
                         C_ARD = 3'd4, C_RPR = 3'd5, C_LWR = 3'd6, C_LRD = 3'd7;

  typedef struct {
    logic [63:0] exp;
    bit          chk;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic        cmd_grp = 1'b0;
  logic [1:0]  cmd_idx = '0;
  logic [63:0] cmd_wdata = '0;
  logic        sel_valid = 1'b0;
  logic [1:0]  sel_idx = '0;
  logic        sel_preempt = 1'b0;
  logic [2:0]  pre_bits = 3'd5;
  logic        nmi_en = 1'b1;
  logic        split_eoi = 1'b0;
  logic [63:0] rdata;
  logic        done;

  int    n_tests = 0;
  int    n_fail  = 0;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vint_ack_eoi u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_grp_i(cmd_grp), .cmd_idx_i(cmd_idx), .cmd_wdata_i(cmd_wdata),
    .sel_valid_i(sel_valid), .sel_idx_i(sel_idx), .sel_preempt_i(sel_preempt),
    .pre_bits_i(pre_bits), .nmi_en_i(nmi_en), .split_eoi_i(split_eoi),
    .rdata_o(rdata), .done_o(done)
  );

  function automatic logic [63:0] mk(input int id, input int prio, input bit g,
                                     input bit n, input bit p, input bit a);
    return {28'd0, a, p, n, g, 8'(prio), 24'(id)};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop and compare on each done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        check("R1 unexpected done", 64'd1, 64'd0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (it.chk) check(it.tag, rdata, it.exp);
      end
    end
  end

  task automatic cmd(input logic [2:0] op, input bit grp, input int idx,
                     input logic [63:0] wd, input int sidx, input bit spre,
                     input logic [63:0] exp, input bit chk, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = exp; it.chk = chk; it.tag = tag;
    sb_q.push_back(it);
    cmd_op = op; cmd_grp = grp; cmd_idx = 2'(idx); cmd_wdata = wd;
    sel_valid = 1'b1; sel_idx = 2'(sidx); sel_preempt = spre;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic lwr(input int idx, input logic [63:0] w);
    cmd(C_LWR, 0, idx, w, 0, 0, 64'd0, 0, "");
  endtask
  task automatic lrd(input int idx, input logic [63:0] exp, input string tag);
    cmd(C_LRD, 0, idx, 64'd0, 0, 0, exp, 1, tag);
  endtask
  task automatic ard(input bit g, input int idx, input logic [63:0] exp, input string tag);
    cmd(C_ARD, g, idx, 64'd0, 0, 0, exp, 1, tag);
  endtask
  task automatic awr(input bit g, input int idx, input logic [63:0] w);
    cmd(C_AWR, g, idx, w, 0, 0, 64'd0, 0, "");
  endtask
  task automatic ack(input bit g, input int sidx, input bit spre, input int exp, input string tag);
    cmd(C_ACK, g, 0, 64'd0, sidx, spre, 64'(exp), 1, tag);
  endtask
  task automatic nack(input int sidx, input int exp, input string tag);
    cmd(C_NACK, 1, 0, 64'd0, sidx, 0, 64'(exp), 1, tag);
  endtask
  task automatic eoi(input bit g, input int id);
    cmd(C_EOI, g, 0, 64'(id), 0, 0, 64'd0, 1, "R1 eoi rdata");
  endtask
  task automatic rpr(input logic [63:0] exp, input string tag);
    cmd(C_RPR, 0, 0, 64'd0, 0, 0, exp, 1, tag);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset done", 64'(done), 64'd0);
    check("R1 reset rdata", rdata, 64'd0);

    // R2 list round trip
    lwr(0, mk(40, 8'h4F, 1, 0, 1, 0));
    lrd(0, mk(40, 8'h4F, 1, 0, 1, 0), "R2 lr roundtrip");

    // R3 acknowledge, masked priority 0x48 -> bit 9
    ack(1, 0, 1, 40, "R3 ack id");
    lrd(0, mk(40, 8'h4F, 1, 0, 0, 1), "R3 lr activated");
    ard(1, 0, 64'h200, "R3 apr bit");

    // R4 refusals
    lwr(1, mk(50, 8'h20, 0, 0, 1, 0));
    ack(1, 1, 1, 1023, "R4 group mismatch");
    ack(0, 1, 0, 1023, "R4 no preempt");
    lrd(1, mk(50, 8'h20, 0, 0, 1, 0), "R4 lr unchanged");
    ack(0, 1, 1, 50, "R3 ack group0");
    ard(0, 0, 64'h10, "R3 apr group0 bit");

    // R13 / R9
    rpr(64'h20, "R13 rpr lowest bit");
    eoi(0, 50);
    lrd(1, mk(50, 8'h20, 0, 0, 0, 0), "R9 eoi deactivates");
    ard(0, 0, 64'h0, "R9 eoi drops bit");
    rpr(64'h48, "R13 rpr after drop");

    // R5 refused NMI acknowledge
    lwr(2, mk(60, 8'h30, 1, 1, 1, 0));
    ack(1, 2, 1, 1022, "R5 nmi refused");
    lrd(2, mk(60, 8'h30, 1, 1, 1, 0), "R5 lr still pending");
    ard(1, 0, 64'h200, "R5 apr unchanged");

    // R6 NMI acknowledge
    nack(2, 60, "R6 nmi ack id");
    lrd(2, mk(60, 8'h30, 1, 1, 0, 1), "R6 nmi lr active");
    ard(1, 0, 64'h8000_0000_0000_0200, "R6 nmi bit only");
    rpr(64'h8000_0000_0000_0080, "R13 rpr nmi");
    lwr(3, mk(70, 8'h10, 1, 0, 1, 0));
    nack(3, 1023, "R6 non-nmi rejected");
    lrd(3, mk(70, 8'h10, 1, 0, 1, 0), "R6 rejected lr unchanged");

    // R8 NMI drop first
    eoi(1, 60);
    lrd(2, mk(60, 8'h30, 1, 1, 0, 0), "R8 nmi lr deactivated");
    ard(1, 0, 64'h200, "R8 nmi bit cleared only");
    eoi(1, 40);
    lrd(0, mk(40, 8'h4F, 1, 0, 0, 0), "R9 masked prio match");
    ard(1, 0, 64'h0, "R9 group1 bit dropped");

    // R10 nothing active
    lwr(3, mk(70, 8'h10, 1, 0, 0, 1));
    eoi(1, 70);
    lrd(3, mk(70, 8'h10, 1, 0, 0, 1), "R10 lr untouched");
    rpr(64'hFF, "R13 rpr idle");
    lwr(3, 64'd0);

    // R7 special IDs
    lwr(0, mk(1021, 8'h40, 1, 0, 1, 0));
    ack(1, 0, 1, 1021, "R7 special id ack");
    lrd(0, mk(1021, 8'h40, 1, 0, 0, 0), "R7 pending cleared not active");
    ard(1, 0, 64'h0, "R7 apr untouched");
    lwr(1, mk(1020, 8'h40, 1, 1, 1, 0));
    nack(1, 1020, "R7 special nmi ack");
    lrd(1, mk(1020, 8'h40, 1, 1, 0, 0), "R7 nmi pending cleared");
    ard(1, 0, 64'h0, "R7 no nmi bit");

    // R12 register writes
    awr(0, 0, 64'h8000_0000_0000_0005);
    ard(0, 0, 64'h5, "R12 group0 drops bit63");
    awr(1, 0, 64'h8000_0000_0000_0005);
    ard(1, 0, 64'h8000_0000_0000_0005, "R12 group1 reg0 keeps bit63");
    rpr(64'h8000_0000_0000_0080, "R13 rpr written nmi");
    awr(1, 2, 64'h8000_0000_0000_0005);
    ard(1, 2, 64'h5, "R12 reg2 drops bit63");
    awr(0, 0, 64'd0); awr(1, 0, 64'd0); awr(1, 2, 64'd0);
    nmi_en = 1'b0;
    awr(1, 0, 64'h8000_0000_0000_0000);
    ard(1, 0, 64'h0, "R12 bit63 dropped without support");

    // R5 / R6 without support
    lwr(2, mk(80, 8'h30, 1, 1, 1, 0));
    nack(2, 1023, "R6 nmi ack without support");
    ack(1, 2, 1, 80, "R5 flag ignored without support");
    ard(1, 0, 64'h40, "R5 normal priority bit");
    eoi(1, 80);
    lrd(2, mk(80, 8'h30, 1, 1, 0, 0), "R9 eoi without support");
    ard(1, 0, 64'h0, "R9 apr cleared");
    nmi_en = 1'b1;

    // R11 split mode
    split_eoi = 1'b1;
    lwr(0, mk(100, 8'h40, 0, 0, 1, 0));
    ack(0, 0, 1, 100, "R3 ack split");
    ard(0, 0, 64'h100, "R3 apr bit 8");
    eoi(0, 100);
    ard(0, 0, 64'h0, "R11 priority dropped");
    lrd(0, mk(100, 8'h40, 0, 0, 0, 1), "R11 low id stays active");
    lwr(0, 64'd0);
    lwr(1, mk(9000, 8'h40, 0, 0, 1, 0));
    ack(0, 1, 1, 9000, "R3 ack lpi range");
    eoi(0, 9000);
    lrd(1, mk(9000, 8'h40, 0, 0, 0, 0), "R11 high id deactivated");
    split_eoi = 1'b0;

    // R3 / R13 with seven preemption bits
    pre_bits = 3'd7;
    lwr(0, mk(5, 8'hFE, 1, 0, 1, 0));
    ack(1, 0, 1, 5, "R3 ack pre7");
    ard(1, 3, 64'h8000_0000, "R3 reg3 bit31");
    rpr(64'hFE, "R13 rpr pre7");
    eoi(1, 5);
    lrd(0, mk(5, 8'hFE, 1, 0, 0, 0), "R9 eoi pre7");
    ard(1, 3, 64'h0, "R9 reg3 cleared");
    pre_bits = 3'd5;

    // R9 group 0 preferred on equal index
    lwr(0, mk(11, 8'h28, 0, 0, 1, 0));
    lwr(1, mk(12, 8'h28, 1, 0, 1, 0));
    ack(0, 0, 1, 11, "R3 ack g0 same prio");
    ack(1, 1, 1, 12, "R3 ack g1 same prio");
    eoi(1, 12);
    ard(0, 0, 64'h0, "R9 group0 bit dropped first");
    ard(1, 0, 64'h20, "R9 group1 bit kept");
    lrd(1, mk(12, 8'h28, 1, 0, 0, 0), "R9 matching lr deactivated");

    repeat (3) @(negedge clk);
    check("R1 idle no done", 64'(done), 64'd0);
    check("R1 all dones seen", 64'(sb_q.size()), 64'd0);
    finish_run();
  end
endmodule